// File: doc/BRIEF.md
# Next Fetch Address Unit

This block picks the address the front end fetches next. Each cycle it looks up the current fetch PC in a small direct-mapped target buffer. On a tag hit it returns the stored target and the kind of branch found there. A direction hint from an outside predictor, the stored branch kind and a circular return-address stack together decide whether fetch moves to the stored target, to the return stack top or to the next sequential instruction.

Resolved branches come back on a write port that installs or overwrites a buffer entry in one cycle. A flush input drops every buffer entry at once, for use when execution moves between security domains. A call found at fetch pushes the address after it. A return found at fetch pops the stack. When the stack is empty the return falls back to its buffered target.

Top module: `nfa_unit`

## Requirements
- R1: After reset the buffer holds no valid entry and the return stack is empty, so every lookup misses and `next_pc` is `fetch_pc + 4`.
- R2: With `fetch_valid` low, or on a buffer miss, `pred_hit` is 0 and `next_pc` is `fetch_pc + 4` whatever `pred_taken` is.
- R3: An entry is selected by `pc[5:2]` and tagged with `pc[13:6]`. Two PCs with the same index and different tags share one entry. Writing one replaces the other, which then misses.
- R4: A hit of kind conditional (code 0) goes to the stored target when `pred_taken` is 1 and to `fetch_pc + 4` when it is 0.
- R5: Hits of kind jump (code 1), indirect (code 2) and call (code 3) go to the stored target with `pred_taken` at 0.
- R6: A call hit pushes `fetch_pc + 4`. A return hit (code 4) with a non-empty stack sends `next_pc` to the stack top, raises `use_ras` and pops one entry.
- R7: A return hit with an empty stack sends `next_pc` to the stored target with `use_ras` low, and the stack stays empty.
- R8: The stack holds 16 addresses. Seventeen calls in a row keep the newest 16, which come back newest first. The seventeenth return then falls back to the stored target.
- R9: A `flush` cycle invalidates every entry. A resolve write in that same cycle is dropped.
- R10: A resolve write and a lookup at the same index in the same cycle: the lookup sees the old entry, and the new one is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A lookup is made this cycle |
| fetch_pc | input | AW | Current fetch address |
| pred_taken | input | 1 | Direction hint for conditional branches |
| rsv_valid | input | 1 | Write a buffer entry |
| rsv_pc | input | AW | Address of the resolved branch |
| rsv_target | input | AW | Resolved target address |
| rsv_kind | input | 3 | Branch kind code (0 cond, 1 jump, 2 indirect, 3 call, 4 return) |
| flush | input | 1 | Invalidate the whole buffer |
| next_pc | output | AW | Chosen next fetch address |
| pred_hit | output | 1 | Lookup hit a valid entry with matching tag |
| use_ras | output | 1 | `next_pc` came from the return stack |

## Verification
The checker assumes that `fetch_valid` is the only qualifier on a lookup. It also assumes that a return-stack push or pop comes only from a fetch hit, so the stack count must stay still on any cycle without a hit. The stimulus drives every input on the falling edge and keeps `fetch_valid` low during install cycles, unless a test wants a lookup in that cycle. Calls and returns therefore move the stack only when a test means them to. Kind codes stay within the five defined values, so the assertions need not cover the undefined codes.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [2:0] {
    BR_COND = 3'd0,
    BR_JUMP = 3'd1,
    BR_IND  = 3'd2,
    BR_CALL = 3'd3,
    BR_RET  = 3'd4
  } br_kind_t;
endpackage

// File: rtl/nfa_rst_sync.sv
module nfa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/nfa_btb.sv
module nfa_btb
  import nfa_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [AW-1:0]    lk_target,
  output br_kind_t         lk_kind,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [AW-1:0]    wr_target,
  input  br_kind_t         wr_kind,
  input  logic             flush
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [AW-1:0]      target_q [ENTRIES];
  br_kind_t           kind_q   [ENTRIES];
  logic               data_we;

  assign data_we = wr_en && !flush;

  always_comb begin
    vld_d = vld_q;
    if (flush)        vld_d = '0;
    else if (wr_en)   vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (data_we) begin
      tag_q[wr_idx]    <= wr_tag;
      target_q[wr_idx] <= wr_target;
      kind_q[wr_idx]   <= wr_kind;
    end
  end

  assign lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_target = target_q[lk_idx];
  assign lk_kind   = kind_q[lk_idx];
endmodule

// File: rtl/nfa_ras.sv
module nfa_ras #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [AW-1:0]                push_addr,
  output logic [AW-1:0]                top_addr,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [AW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, wr_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  assign wr_ptr = head_q + PTR_W'(1);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign empty  = (cnt_q == '0);

  always_comb begin
    head_d = head_q;
    cnt_d  = cnt_q;
    if (push) begin
      head_d = wr_ptr;
      if (!full) cnt_d = cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      head_d = head_q - PTR_W'(1);
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr] <= push_addr;
  end

  assign top_addr = mem_q[head_q];
  assign count    = cnt_q;
endmodule

// File: rtl/nfa_select.sv
module nfa_select
  import nfa_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          hit,
  input  br_kind_t      kind,
  input  logic          pred_taken,
  input  logic [AW-1:0] btb_target,
  input  logic [AW-1:0] seq_pc,
  input  logic [AW-1:0] ras_top,
  input  logic          ras_empty,
  output logic [AW-1:0] next_pc,
  output logic          use_ras,
  output logic          do_push,
  output logic          do_pop
);
  always_comb begin
    next_pc = seq_pc;
    use_ras = 1'b0;
    do_push = 1'b0;
    do_pop  = 1'b0;
    if (hit) begin
      unique case (kind)
        BR_COND: if (pred_taken) next_pc = btb_target;
        BR_JUMP, BR_IND: next_pc = btb_target;
        BR_CALL: begin
          next_pc = btb_target;
          do_push = 1'b1;
        end
        BR_RET: begin
          if (!ras_empty) begin
            next_pc = ras_top;
            use_ras = 1'b1;
            do_pop  = 1'b1;
          end else begin
            next_pc = btb_target;
          end
        end
        default: next_pc = seq_pc;
      endcase
    end
  end
endmodule

// File: rtl/nfa_unit.sv
module nfa_unit
  import nfa_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IDX_W      = 4,
  parameter int TAG_W      = 8,
  parameter int RAS_DEPTH  = 16,
  parameter int INST_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          pred_taken,
  input  logic          rsv_valid,
  input  logic [AW-1:0] rsv_pc,
  input  logic [AW-1:0] rsv_target,
  input  logic [2:0]    rsv_kind,
  input  logic          flush,
  output logic [AW-1:0] next_pc,
  output logic          pred_hit,
  output logic          use_ras
);
  localparam int OFF_W = $clog2(INST_BYTES);
  localparam int TAG_LO = OFF_W + IDX_W;
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);

  logic             rst_n_sync;
  logic             lk_hit;
  logic [AW-1:0]    lk_target;
  br_kind_t         lk_kind;
  logic [AW-1:0]    seq_pc;
  logic [AW-1:0]    ras_top;
  logic             ras_empty;
  logic [CNT_W-1:0] ras_cnt;
  logic             do_push, do_pop;
  logic             unused_rsv_bits;

  assign unused_rsv_bits = ^{rsv_pc[OFF_W-1:0], rsv_pc[AW-1:TAG_LO+TAG_W]};

  nfa_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  nfa_btb #(.AW(AW), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_btb (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .lk_idx    (fetch_pc[OFF_W +: IDX_W]),
    .lk_tag    (fetch_pc[TAG_LO +: TAG_W]),
    .lk_hit    (lk_hit),
    .lk_target (lk_target),
    .lk_kind   (lk_kind),
    .wr_en     (rsv_valid),
    .wr_idx    (rsv_pc[OFF_W +: IDX_W]),
    .wr_tag    (rsv_pc[TAG_LO +: TAG_W]),
    .wr_target (rsv_target),
    .wr_kind   (br_kind_t'(rsv_kind)),
    .flush     (flush)
  );

  assign pred_hit = fetch_valid && lk_hit;
  assign seq_pc   = fetch_pc + AW'(INST_BYTES);

  nfa_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) i_ras (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .push      (do_push),
    .pop       (do_pop),
    .push_addr (seq_pc),
    .top_addr  (ras_top),
    .empty     (ras_empty),
    .count     (ras_cnt)
  );

  nfa_select #(.AW(AW)) i_select (
    .hit        (pred_hit),
    .kind       (lk_kind),
    .pred_taken (pred_taken),
    .btb_target (lk_target),
    .seq_pc     (seq_pc),
    .ras_top    (ras_top),
    .ras_empty  (ras_empty),
    .next_pc    (next_pc),
    .use_ras    (use_ras),
    .do_push    (do_push),
    .do_pop     (do_pop)
  );
endmodule

// File: rtl/nfa_unit_chk.sv
module nfa_unit_chk #(
  parameter int AW         = 32,
  parameter int RAS_DEPTH  = 16,
  parameter int INST_BYTES = 4,
  localparam int CNT_W     = $clog2(RAS_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             fetch_valid,
  input logic [AW-1:0]    fetch_pc,
  input logic             flush,
  input logic [AW-1:0]    next_pc,
  input logic             pred_hit,
  input logic             use_ras,
  input logic [CNT_W-1:0] ras_cnt
);
  assert_miss_seq_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !pred_hit |-> next_pc == fetch_pc + AW'(INST_BYTES));

  assert_hit_needs_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    pred_hit |-> fetch_valid);

  assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    use_ras |=> ras_cnt == $past(ras_cnt) - CNT_W'(1));

  assert_idle_stack_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !pred_hit |=> $stable(ras_cnt));

  assert_empty_no_ras_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    use_ras |-> ras_cnt != '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ras_cnt <= CNT_W'(RAS_DEPTH));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    flush |=> !pred_hit);
endmodule

bind nfa_unit nfa_unit_chk #(
  .AW(AW), .RAS_DEPTH(RAS_DEPTH), .INST_BYTES(INST_BYTES)
) i_nfa_unit_chk (
  .clk         (clk),
  .rst_n_sync  (rst_n_sync),
  .fetch_valid (fetch_valid),
  .fetch_pc    (fetch_pc),
  .flush       (flush),
  .next_pc     (next_pc),
  .pred_hit    (pred_hit),
  .use_ras     (use_ras),
  .ras_cnt     (ras_cnt)
);

// File: tb/test_nfa_unit.sv
module test_nfa_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          pred_taken;
  logic          rsv_valid;
  logic [AW-1:0] rsv_pc;
  logic [AW-1:0] rsv_target;
  logic [2:0]    rsv_kind;
  logic          flush;
  logic [AW-1:0] next_pc;
  logic          pred_hit;
  logic          use_ras;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [AW-1:0] RET_TGT = 32'h0000_8800;

  nfa_unit i_nfa_unit (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .rsv_valid(rsv_valid), .rsv_pc(rsv_pc),
    .rsv_target(rsv_target), .rsv_kind(rsv_kind), .flush(flush),
    .next_pc(next_pc), .pred_hit(pred_hit), .use_ras(use_ras)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [AW-1:0] mkpc(int idx, int tag);
    return AW'((tag << 6) | (idx << 2));
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(string req, logic [AW-1:0] npc, logic hit, logic ras);
    chk(req, "next_pc", next_pc, npc);
    chk(req, "pred_hit", AW'(pred_hit), AW'(hit));
    chk(req, "use_ras", AW'(use_ras), AW'(ras));
  endtask

  task automatic install(logic [AW-1:0] pc, logic [AW-1:0] tgt, logic [2:0] kind);
    fetch_valid = 1'b0;
    rsv_valid = 1'b1; rsv_pc = pc; rsv_target = tgt; rsv_kind = kind;
    step();
    rsv_valid = 1'b0;
  endtask

  task automatic probe(logic [AW-1:0] pc, logic hint);
    fetch_valid = 1'b1; fetch_pc = pc; pred_taken = hint;
    #1;
  endtask

  task automatic idle();
    fetch_valid = 1'b0;
  endtask

  task automatic t_reset();
    probe(mkpc(0, 0), 1'b1);
    expect_out("R1", mkpc(0, 0) + 4, 1'b0, 1'b0);
    probe(mkpc(5, 9), 1'b1);
    expect_out("R1", mkpc(5, 9) + 4, 1'b0, 1'b0);
    idle();
  endtask

  task automatic t_miss();
    install(mkpc(3, 5), 32'h0000_5000, 3'd1);
    probe(mkpc(3, 6), 1'b1);
    expect_out("R2", mkpc(3, 6) + 4, 1'b0, 1'b0);
    fetch_valid = 1'b0; fetch_pc = mkpc(3, 5); #1;
    expect_out("R2", mkpc(3, 5) + 4, 1'b0, 1'b0);
    idle();
  endtask

  task automatic t_alias();
    probe(mkpc(3, 5), 1'b0);
    expect_out("R3", 32'h0000_5000, 1'b1, 1'b0);
    idle();
    install(mkpc(3, 6), 32'h0000_6000, 3'd1);
    probe(mkpc(3, 5), 1'b0);
    expect_out("R3", mkpc(3, 5) + 4, 1'b0, 1'b0);
    probe(mkpc(3, 6), 1'b0);
    expect_out("R3", 32'h0000_6000, 1'b1, 1'b0);
    probe(mkpc(4, 6), 1'b1);
    expect_out("R3", mkpc(4, 6) + 4, 1'b0, 1'b0);
    idle();
  endtask

  task automatic t_cond();
    install(mkpc(1, 2), 32'h0000_4000, 3'd0);
    probe(mkpc(1, 2), 1'b1);
    expect_out("R4", 32'h0000_4000, 1'b1, 1'b0);
    probe(mkpc(1, 2), 1'b0);
    expect_out("R4", mkpc(1, 2) + 4, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_uncond();
    install(mkpc(5, 1), 32'h0000_1500, 3'd1);
    install(mkpc(6, 1), 32'h0000_1600, 3'd2);
    install(mkpc(8, 3), 32'h0000_9000, 3'd3);
    probe(mkpc(5, 1), 1'b0);
    expect_out("R5", 32'h0000_1500, 1'b1, 1'b0);
    probe(mkpc(6, 1), 1'b0);
    expect_out("R5", 32'h0000_1600, 1'b1, 1'b0);
    probe(mkpc(8, 3), 1'b0);
    expect_out("R5", 32'h0000_9000, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_ret_empty();
    install(mkpc(7, 1), RET_TGT, 3'd4);
    probe(mkpc(7, 1), 1'b0);
    expect_out("R7", RET_TGT, 1'b1, 1'b0);
    step();
    probe(mkpc(7, 1), 1'b1);
    expect_out("R7", RET_TGT, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_call_ret();
    probe(mkpc(8, 3), 1'b0);
    expect_out("R6", 32'h0000_9000, 1'b1, 1'b0);
    step();
    probe(mkpc(7, 1), 1'b0);
    expect_out("R6", mkpc(8, 3) + 4, 1'b1, 1'b1);
    step();
    probe(mkpc(7, 1), 1'b0);
    expect_out("R6", RET_TGT, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_overflow();
    for (int k = 1; k <= 17; k++) begin
      install(mkpc(9, k), 32'h0000_A000, 3'd3);
      probe(mkpc(9, k), 1'b0);
      step();
      idle();
    end
    for (int j = 0; j < 16; j++) begin
      probe(mkpc(7, 1), 1'b0);
      expect_out("R8", mkpc(9, 17 - j) + 4, 1'b1, 1'b1);
      step();
    end
    probe(mkpc(7, 1), 1'b0);
    expect_out("R8", RET_TGT, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_same_cycle();
    install(mkpc(10, 1), 32'h0000_1100, 3'd0);
    rsv_valid = 1'b1; rsv_pc = mkpc(10, 1); rsv_target = 32'h0000_2200; rsv_kind = 3'd0;
    probe(mkpc(10, 1), 1'b1);
    expect_out("R10", 32'h0000_1100, 1'b1, 1'b0);
    step();
    rsv_valid = 1'b0;
    probe(mkpc(10, 1), 1'b1);
    expect_out("R10", 32'h0000_2200, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_flush();
    install(mkpc(11, 1), 32'h0000_3300, 3'd1);
    probe(mkpc(11, 1), 1'b0);
    expect_out("R9", 32'h0000_3300, 1'b1, 1'b0);
    idle();
    flush = 1'b1;
    rsv_valid = 1'b1; rsv_pc = mkpc(12, 1); rsv_target = 32'h0000_4400; rsv_kind = 3'd1;
    step();
    flush = 1'b0; rsv_valid = 1'b0;
    probe(mkpc(11, 1), 1'b1);
    expect_out("R9", mkpc(11, 1) + 4, 1'b0, 1'b0);
    probe(mkpc(12, 1), 1'b1);
    expect_out("R9", mkpc(12, 1) + 4, 1'b0, 1'b0);
    probe(mkpc(1, 2), 1'b1);
    expect_out("R9", mkpc(1, 2) + 4, 1'b0, 1'b0);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_pc = '0; pred_taken = 1'b0;
    rsv_valid = 1'b0; rsv_pc = '0; rsv_target = '0; rsv_kind = 3'd0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_miss();
    t_alias();
    t_cond();
    t_uncond();
    t_ret_empty();
    t_call_ret();
    t_overflow();
    t_same_cycle();
    t_flush();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule